// File: doc/BRIEF.md
# Grouped Event Code Selector

The selector sits between a cache's raw event sources and a bank of event counters. The raw events form a grid of eight groups (columns). Each group has 256 possible events (rows), and each event is addressed by an 8-bit code. A single 64-bit code register holds one live code per group. Every counter has a small type register that names the group it follows, so a counter picks a column rather than a full event number. Two counters can never watch two different rows of the same column at once.

Each counter also has an origin filter register. It passes or blocks events according to the sub-unit and the origin class that the event sources report with every cycle. Bit 63 of the code register is a master enable for the whole selection path. Each counter gets one registered count pulse per clock, one cycle after the raw event is sampled. Software sees a flat write and read port. A change to one group's code is made by reading the code register, replacing one byte and writing the word back.

Top module: `evsel_top`

## Requirements
- R1: After reset the code register reads 0, every type register reads 0xF, every filter register reads 0x000E0007, and all count outputs are low.
- R2: Register map on an 8-bit address: 0x00 is the 64-bit code register, 0x10+c is counter c's type register (4 bits, zero-extended on read), and 0x20+c is counter c's filter register (32 bits, zero-extended). A write takes effect at the clock edge, and the read port shows the stored value combinationally.
- R3: Group g's code is held in code register bits [8g+7:8g]. A counter whose type is g, with the enable set and the filter passing, raises its count output in the cycle after raw event input bit g*256+code was high.
- R4: When code register bit 63 is 0, every count output is low in the following cycle.
- R5: A type register value of 8 or more selects no group, and that counter's output stays low.
- R6: Two counters with the same type and the same filter produce identical count pulses.
- R7: Filter bits 17, 18 and 19 enable events from sub-units 0, 1 and 2 (src_unit_i). Sub-unit 3 never passes.
- R8: Filter bits 0 and 1 enable origin ids 0 and 1. Bit 2 enables origin-independent events (src_org_i = 2). Origin code 3 never passes.
- R9: Writing one register leaves all other registers unchanged. A read-modify-write of one group's byte in the code register keeps the other seven codes and the enable.
- R10: A write to an unmapped address changes no register, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 64 | Read data, combinational |
| raw_evt_i | input | 2048 | Raw event pulses, bit g*256+code |
| src_unit_i | input | 2 | Sub-unit of this cycle's events |
| src_org_i | input | 2 | Origin class of this cycle's events |
| cnt_evt_o | output | NUM_CTRS | Registered count pulse per counter |

## Verification
Several properties are checked on every cycle. The output is blanked when the enable is off, when the type is out of range, or when the sub-unit or origin is blocked. A write to another address leaves the code register alone, an unmapped write changes nothing, and two identically set counters agree. Some behaviour can only be shown by the bench scenarios. These are the choice of the correct row within a column for each code, the exact filter bit-to-source mapping under mixed traffic, the read-modify-write of a single group byte, and the reset values. The bench compares all outputs every clock against a behavioural model.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int SEL_W   = 64;
  localparam int EN_BIT  = 63;
  localparam int ADDR_W  = 8;
  localparam int TYPE_W  = 4;
  localparam int FILT_W  = 32;
  localparam logic [3:0] PAGE_SEL  = 4'h0;
  localparam logic [3:0] PAGE_TYPE = 4'h1;
  localparam logic [3:0] PAGE_FILT = 4'h2;
  localparam int UNIT_LSB = 17;  // sub-unit enables 17..19
  localparam int NUM_UNIT = 3;
  localparam int NUM_ORG  = 3;   // origin enables 0..2, 2 = origin-independent
  localparam logic [FILT_W-1:0] FILT_PASS_ALL = 32'h000E_0007;
endpackage

// File: rtl/evsel_regs.sv
module evsel_regs
  import evsel_pkg::*;
#(
  parameter int NUM_CTRS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [SEL_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [SEL_W-1:0]           rd_data_o,
  output logic [SEL_W-1:0]           sel_o,
  output logic [NUM_CTRS*TYPE_W-1:0] type_o,
  output logic [NUM_CTRS*FILT_W-1:0] filt_o
);
  logic [SEL_W-1:0]                     sel_q;
  logic [NUM_CTRS-1:0][TYPE_W-1:0]      type_q;
  logic [NUM_CTRS-1:0][FILT_W-1:0]      filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      type_q <= '1;
      for (int c = 0; c < NUM_CTRS; c++) filt_q[c] <= FILT_PASS_ALL;
    end else if (wr_en_i) begin
      if (wr_addr_i == {PAGE_SEL, 4'h0}) sel_q <= wr_data_i;
      for (int c = 0; c < NUM_CTRS; c++) begin
        if (wr_addr_i == {PAGE_TYPE, 4'(c)}) type_q[c] <= wr_data_i[TYPE_W-1:0];
        if (wr_addr_i == {PAGE_FILT, 4'(c)}) filt_q[c] <= wr_data_i[FILT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == {PAGE_SEL, 4'h0}) rd_data_o = sel_q;
    for (int c = 0; c < NUM_CTRS; c++) begin
      if (rd_addr_i == {PAGE_TYPE, 4'(c)}) rd_data_o[TYPE_W-1:0] = type_q[c];
      if (rd_addr_i == {PAGE_FILT, 4'(c)}) rd_data_o[FILT_W-1:0] = filt_q[c];
    end
  end

  assign sel_o  = sel_q;
  assign type_o = type_q;
  assign filt_o = filt_q;

  // R9: other addresses leave the code register alone
  a_r9_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != 8'h00) |=> $stable(sel_q));

  // R10: pages above filter page are unmapped
  a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[7:4] > PAGE_FILT) |=>
      ($stable(sel_q) && $stable(type_q) && $stable(filt_q)));
endmodule

// File: rtl/evsel_col_pick.sv
module evsel_col_pick
  import evsel_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8
) (
  input  logic [(NUM_GROUPS<<CODE_W)-1:0] raw_evt_i,
  input  logic [SEL_W-1:0]                sel_i,
  output logic [NUM_GROUPS-1:0]           col_hit_o
);
  localparam int ROWS = 1 << CODE_W;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_col
    logic [ROWS-1:0]   col;
    logic [CODE_W-1:0] code;
    assign col          = raw_evt_i[g*ROWS +: ROWS];
    assign code         = sel_i[g*CODE_W +: CODE_W];
    assign col_hit_o[g] = col[code];
  end
endmodule

// File: rtl/evsel_ctr_gate.sv
module evsel_ctr_gate
  import evsel_pkg::*;
#(
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_GROUPS-1:0] col_hit_i,
  input  logic                  en_i,
  input  logic [TYPE_W-1:0]     type_i,
  input  logic [FILT_W-1:0]     filt_i,
  input  logic [1:0]            src_unit_i,
  input  logic [1:0]            src_org_i,
  output logic                  cnt_o
);
  localparam int GSEL_W = $clog2(NUM_GROUPS);

  logic type_ok, unit_ok, org_ok, hit;

  assign type_ok = ({1'b0, type_i} < (TYPE_W+1)'(NUM_GROUPS));
  assign unit_ok = (int'(src_unit_i) < NUM_UNIT) && filt_i[UNIT_LSB + int'(src_unit_i)];
  assign org_ok  = (int'(src_org_i) < NUM_ORG) && filt_i[src_org_i];
  assign hit     = en_i && type_ok && unit_ok && org_ok && col_hit_i[type_i[GSEL_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= 1'b0;
    else         cnt_o <= hit;
  end

  a_r4_master_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cnt_o);
  a_r5_type_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_i >= TYPE_W'(NUM_GROUPS)) |=> !cnt_o);
  a_r7_unit_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_unit_i == 2'd3) |=> !cnt_o);
  a_r8_org_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_org_i == 2'd3) |=> !cnt_o);
endmodule

// File: rtl/evsel_top.sv
module evsel_top
  import evsel_pkg::*;
#(
  parameter int NUM_CTRS   = 4,
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [SEL_W-1:0]                wr_data_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  output logic [SEL_W-1:0]                rd_data_o,
  input  logic [(NUM_GROUPS<<CODE_W)-1:0] raw_evt_i,
  input  logic [1:0]                      src_unit_i,
  input  logic [1:0]                      src_org_i,
  output logic [NUM_CTRS-1:0]             cnt_evt_o
);
  logic [SEL_W-1:0]           sel;
  logic [NUM_CTRS*TYPE_W-1:0] types;
  logic [NUM_CTRS*FILT_W-1:0] filts;
  logic [NUM_GROUPS-1:0]      col_hit;

  evsel_regs #(.NUM_CTRS(NUM_CTRS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .sel_o(sel), .type_o(types), .filt_o(filts)
  );

  evsel_col_pick #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_pick (
    .raw_evt_i, .sel_i(sel), .col_hit_o(col_hit)
  );

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    evsel_ctr_gate #(.NUM_GROUPS(NUM_GROUPS)) u_gate (
      .clk_i, .rst_ni,
      .col_hit_i (col_hit),
      .en_i      (sel[EN_BIT]),
      .type_i    (types[c*TYPE_W +: TYPE_W]),
      .filt_i    (filts[c*FILT_W +: FILT_W]),
      .src_unit_i, .src_org_i,
      .cnt_o     (cnt_evt_o[c])
    );
  end

  if (NUM_CTRS >= 2) begin : g_pair_chk
    // R6: matching configuration on counters 0 and 1 gives matching pulses
    a_r6_same_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (types[0 +: TYPE_W] == types[TYPE_W +: TYPE_W] &&
       filts[0 +: FILT_W] == filts[FILT_W +: FILT_W]) |=>
        (cnt_evt_o[0] == cnt_evt_o[1]));
  end
endmodule

// File: tb/evsel_top_tb_top.sv
`timescale 1ns/1ps
module evsel_top_tb_top;
  localparam int NC = 4;
  localparam int EW = 2048;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    wr_addr_i = '0;
  logic [63:0]   wr_data_i = '0;
  logic [7:0]    rd_addr_i = '0;
  logic [63:0]   rd_data_o;
  logic [EW-1:0] raw_evt_i = '0;
  logic [1:0]    src_unit_i = '0;
  logic [1:0]    src_org_i = '0;
  logic [NC-1:0] cnt_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_sel;
  logic [3:0]  m_typ [NC];
  logic [31:0] m_filt[NC];
  logic [NC-1:0] exp_cnt;

  always #2 clk_i = ~clk_i;

  evsel_top dut_i (.*);

  function automatic logic [63:0] mread(input logic [7:0] a);
    if (a == 8'h00) return m_sel;
    if (a >= 8'h10 && a < 8'h10 + NC) return {60'b0, m_typ[a - 8'h10]};
    if (a >= 8'h20 && a < 8'h20 + NC) return {32'b0, m_filt[a - 8'h20]};
    return 64'b0;
  endfunction

  function automatic logic [NC-1:0] model_out();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      int t = int'(m_typ[c]);
      int code;
      bit up, op;
      if (!m_sel[63] || t > 7) continue;
      code = int'((m_sel >> (8*t)) & 64'hFF);
      up = (src_unit_i < 3) && m_filt[c][17 + int'(src_unit_i)];
      op = (src_org_i < 3) && m_filt[c][int'(src_org_i)];
      r[c] = raw_evt_i[t*256 + code] && up && op;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: predict, advance, update model, compare
  task automatic cycle(input string req);
    exp_cnt = model_out();
    @(posedge clk_i);
    if (wr_en_i) begin
      if (wr_addr_i == 8'h00) m_sel = wr_data_i;
      else if (wr_addr_i >= 8'h10 && wr_addr_i < 8'h10 + NC) m_typ[wr_addr_i - 8'h10] = wr_data_i[3:0];
      else if (wr_addr_i >= 8'h20 && wr_addr_i < 8'h20 + NC) m_filt[wr_addr_i - 8'h20] = wr_data_i[31:0];
    end
    @(negedge clk_i);
    chk(req, 64'(cnt_evt_o), 64'(exp_cnt));
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input string req);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cycle(req);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    rd_addr_i = a; #0.5;
    chk(req, rd_data_o, mread(a));
  endtask

  task automatic traffic(input int n, input bit rnd_src, input string req);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < EW/32; k++) raw_evt_i[k*32 +: 32] = $urandom;
      if (rnd_src) begin src_unit_i = 2'($urandom); src_org_i = 2'($urandom); end
      cycle(req);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    m_sel = '0;
    for (int c = 0; c < NC; c++) begin m_typ[c] = 4'hF; m_filt[c] = 32'h000E0007; end
    repeat (3) @(negedge clk_i);
    chk("R1 reset out", 64'(cnt_evt_o), 64'b0);
    rst_ni = 1'b1;
    // R1 reset values
    rd(8'h00, "R1 sel");
    for (int c = 0; c < NC; c++) begin rd(8'(8'h10 + c), "R1 type"); rd(8'(8'h20 + c), "R1 filt"); end
    // R2/R3 program codes and groups
    wr(8'h00, 64'h8000_0000_0000_0000 | 64'h0011_2233_4455_66F7, "R2 wr sel");
    for (int c = 0; c < NC; c++) wr(8'(8'h10 + c), 64'(c * 2 + 1), "R2 wr type");
    rd(8'h00, "R2 sel rd");
    for (int c = 0; c < NC; c++) rd(8'(8'h10 + c), "R2 type rd");
    traffic(40, 1'b0, "R3 col pick");
    // R3 directed: group 1 code 0x66 only
    raw_evt_i = '0; raw_evt_i[1*256 + 8'h66] = 1'b1;
    cycle("R3 directed");
    chk("R3 directed ctr0", 64'(cnt_evt_o[0]), 64'd1);
    // R6 two counters on group 5
    wr(8'h10, 64'd5, "R6 type0"); wr(8'h11, 64'd5, "R6 type1");
    traffic(30, 1'b0, "R6 same group");
    chk("R6 pair", 64'(cnt_evt_o[0]), 64'(cnt_evt_o[1]));
    // R5 out of range types
    wr(8'h12, 64'd9, "R5 type9"); wr(8'h13, 64'd8, "R5 type8");
    traffic(20, 1'b0, "R5 type range");
    // R7/R8 filters
    wr(8'h20, 64'h0004_0001, "R7 filt0");
    wr(8'h21, 64'h0008_0004, "R8 filt1");
    traffic(80, 1'b1, "R7 R8 filter");
    src_unit_i = 2'd0; src_org_i = 2'd0;
    // R9 read-modify-write of group 3 byte
    rd_addr_i = 8'h00; #0.5;
    v = rd_data_o;
    v[31:24] = 8'hA5;
    wr(8'h00, v, "R9 rmw");
    rd(8'h00, "R9 rmw readback");
    wr(8'h22, 64'h1234, "R9 other reg");
    rd(8'h00, "R9 sel kept");
    rd(8'h21, "R9 filt kept");
    // R10 unmapped
    wr(8'h30, 64'hFFFF_FFFF_FFFF_FFFF, "R10 wr 30");
    wr(8'h01, 64'h0, "R10 wr 01");
    wr(8'h1F, 64'h0, "R10 wr 1F");
    rd(8'h30, "R10 rd 30"); rd(8'h1F, "R10 rd 1F");
    rd(8'h00, "R10 sel kept");
    for (int c = 0; c < NC; c++) rd(8'(8'h10 + c), "R10 type kept");
    traffic(10, 1'b1, "R10 traffic");
    // R4 master enable off
    v = m_sel; v[63] = 1'b0;
    wr(8'h00, v, "R4 disable");
    traffic(20, 1'b1, "R4 disabled");
    chk("R4 out low", 64'(cnt_evt_o), 64'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule